// File: doc/BRIEF.md
# Ring Instruction Transport Node

This block is one stop on a one-way ring that is one byte wide. The ring carries configuration programs from a fetch unit to a chain of compute kernels. A program is a series of segments. Each segment opens with a header byte that names a kernel. A second byte follows and gives the number of 32-bit payload words in the segment.

The node tracks segment boundaries on every byte it sees. When the header names its own kernel, it gathers the payload bytes into words, least significant byte first. It hands each word to the kernel's register file over a valid/ready port, one word per cycle. The words are raw register values and are not decoded.

Every byte, captured or not, is passed on to the next node after one register stage, so nodes further along can still follow the segment framing. Backpressure from either the next node or the kernel stalls the ring instead of dropping data.

Top module: `ring_xport_node`

## Requirements
- R1: After reset (synchronous, active-low `rst_n`), `dn_valid` and `wd_valid` are 0 and `up_ready` is 1. The node is in header search, and any partially gathered word is discarded.
- R2: Every byte accepted from upstream (`up_valid && up_ready`) appears unchanged on `dn_data`, with `dn_valid` high, in the following cycle. This includes header, count and payload bytes, and the order is preserved.
- R3: The first byte of a segment is the kernel ID and the second is the payload length N in 32-bit words. When the ID equals the parameter `NODE_ID`, the N words are delivered on the word port.
- R4: Payload byte k of a word (k = 0..3, in arrival order) occupies `wd_data[8k+7:8k]`.
- R5: Exactly N words are taken. The byte after the last payload byte is treated as a new header.
- R6: When the ID does not match, the 4N payload bytes are skipped: no word is emitted, and payload bytes that equal `NODE_ID` are not taken as headers.
- R7: A length byte of 0 ends the segment at once, and the next byte is a header.
- R8: While `wd_valid` is high and `wd_ready` is low, `wd_data` holds steady. If the byte that would complete the next word is offered in that state, `up_ready` is 0 and no byte is lost.
- R9: While `dn_valid` is high and `dn_ready` is low, `dn_data` holds steady and `up_ready` is 0.
- R10: `wd_valid` rises in the cycle right after the fourth byte of a word is accepted, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_data | input | 8 | Ring byte from the upstream node |
| up_valid | input | 1 | Upstream byte present |
| up_ready | output | 1 | Node accepts the upstream byte |
| dn_data | output | 8 | Ring byte to the downstream node |
| dn_valid | output | 1 | Downstream byte present |
| dn_ready | input | 1 | Downstream node accepts the byte |
| wd_data | output | 32 | Assembled instruction word to the kernel |
| wd_valid | output | 1 | Instruction word present |
| wd_ready | input | 1 | Kernel accepts the word |

## Verification
The bench builds the node with `NODE_ID` = 5 and keeps the default 8-bit bytes and 4-byte words. Because the ID is 5, payload bytes of value 5 can be placed inside foreign segments and inside the node's own words. This exercises both false header matches and the matching path. The stream mixes matching, foreign and zero-length segments, so boundary tracking is shown across every segment kind. The 4-byte word width gives a fourth-byte stall point that can be reached by holding the kernel port not ready.

// File: rtl/ring_xport_pkg.sv
// Shared types for the ring instruction transport node.
package ring_xport_pkg;
    // Segment parsing phase: waiting for header, waiting for length, in payload.
    typedef enum logic [1:0] {
        SEG_HDR  = 2'd0,
        SEG_LEN  = 2'd1,
        SEG_BODY = 2'd2
    } seg_state_e;
endpackage

// File: rtl/ring_seg_tracker.sv
// Follows segment framing on the ring byte stream: header, length, payload.
// Assumes take is asserted only for accepted bytes; WORD_BYTES >= 2.
module ring_seg_tracker
    import ring_xport_pkg::*;
#(
    parameter int                 BYTE_W     = 8,
    parameter int                 WORD_BYTES = 4,
    parameter logic [BYTE_W-1:0]  NODE_ID    = '0,
    localparam int                LANE_W     = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              body_mine,
    output logic [LANE_W-1:0] lane_idx,
    output logic              last_lane
);
    localparam logic [LANE_W-1:0] LAST = LANE_W'(WORD_BYTES - 1);

    seg_state_e        state;
    logic              mine;
    logic [BYTE_W-1:0] words_left;
    logic [LANE_W-1:0] lane;

    // Advance the framing state on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SEG_HDR;
            mine       <= 1'b0;
            words_left <= '0;
            lane       <= '0;
        end else if (take) begin
            unique case (state)
                SEG_HDR: begin
                    mine  <= (byte_in == NODE_ID);
                    state <= SEG_LEN;
                end
                SEG_LEN: begin
                    words_left <= byte_in;
                    lane       <= '0;
                    state      <= (byte_in == '0) ? SEG_HDR : SEG_BODY;
                end
                SEG_BODY: begin
                    if (lane == LAST) begin
                        lane       <= '0;
                        words_left <= words_left - 1'b1;
                        if (words_left == BYTE_W'(1)) state <= SEG_HDR;
                    end else begin
                        lane <= lane + LANE_W'(1);
                    end
                end
                default: state <= SEG_HDR;
            endcase
        end
    end

    // Expose the payload position to the packer and stall logic.
    always_comb begin
        body_mine = (state == SEG_BODY) && mine;
        lane_idx  = lane;
        last_lane = (lane == LAST);
    end
endmodule

// File: rtl/ring_word_packer.sv
// Gathers captured bytes little-endian into a word and holds it until taken.
// Assumes the top never asserts cap on the last lane while the word is held.
module ring_word_packer #(
    parameter int  BYTE_W     = 8,
    parameter int  WORD_BYTES = 4,
    localparam int LANE_W     = $clog2(WORD_BYTES),
    localparam int WORD_W     = BYTE_W * WORD_BYTES,
    localparam int HOLD_W     = BYTE_W * (WORD_BYTES - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [LANE_W-1:0] lane_idx,
    input  logic              last_lane,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              wd_ready,
    output logic [WORD_W-1:0] wd_data,
    output logic              wd_valid
);
    logic [HOLD_W-1:0] held;
    logic [WORD_W-1:0] word_next;

    // Store the lower lanes as they arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (cap && !last_lane) begin
            for (int i = 0; i < WORD_BYTES - 1; i++) begin
                if (lane_idx == LANE_W'(i)) held[i*BYTE_W +: BYTE_W] <= byte_in;
            end
        end
    end

    // Combine the held lanes with the final byte.
    generate
        for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_lane
            assign word_next[g*BYTE_W +: BYTE_W] = held[g*BYTE_W +: BYTE_W];
        end
    endgenerate
    assign word_next[WORD_W-1 -: BYTE_W] = byte_in;

    // Output word register with valid/ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_valid <= 1'b0;
            wd_data  <= '0;
        end else if (cap && last_lane) begin
            wd_valid <= 1'b1;
            wd_data  <= word_next;
        end else if (wd_ready) begin
            wd_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ring_fwd_stage.sv
// One register stage that passes every accepted byte to the next ring node.
// Assumes take is asserted only when free is high.
module ring_fwd_stage #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              dn_ready,
    output logic [BYTE_W-1:0] dn_data,
    output logic              dn_valid,
    output logic              free
);
    // Slot is free when empty or being drained this cycle.
    assign free = !dn_valid || dn_ready;

    // Load or drain the forwarding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            dn_data  <= '0;
        end else if (take) begin
            dn_valid <= 1'b1;
            dn_data  <= byte_in;
        end else if (dn_ready) begin
            dn_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ring_xport_node.sv
// Ring transport node: forwards all bytes and extracts the words of segments
// addressed to NODE_ID. Assumes the stream starts on a segment header after reset.
module ring_xport_node #(
    parameter int                 BYTE_W     = 8,
    parameter int                 WORD_BYTES = 4,
    parameter logic [BYTE_W-1:0]  NODE_ID    = 8'h01,
    localparam int                WORD_W     = BYTE_W * WORD_BYTES,
    localparam int                LANE_W     = $clog2(WORD_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] up_data,
    input  logic              up_valid,
    output logic              up_ready,
    output logic [BYTE_W-1:0] dn_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [WORD_W-1:0] wd_data,
    output logic              wd_valid,
    input  logic              wd_ready
);
    logic              fwd_free;
    logic              body_mine;
    logic              last_lane;
    logic [LANE_W-1:0] lane_idx;
    logic              take;
    logic              cap;

    // Accept a byte only if the forward slot is free and a completed word has room.
    always_comb begin
        up_ready = fwd_free && !(body_mine && last_lane && wd_valid && !wd_ready);
        take     = up_valid && up_ready;
        cap      = take && body_mine;
    end

    ring_seg_tracker #(
        .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .NODE_ID(NODE_ID)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .take(take), .byte_in(up_data),
        .body_mine(body_mine), .lane_idx(lane_idx), .last_lane(last_lane)
    );

    ring_word_packer #(
        .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)
    ) u_pack (
        .clk(clk), .rst_n(rst_n), .cap(cap), .lane_idx(lane_idx),
        .last_lane(last_lane), .byte_in(up_data), .wd_ready(wd_ready),
        .wd_data(wd_data), .wd_valid(wd_valid)
    );

    ring_fwd_stage #(
        .BYTE_W(BYTE_W)
    ) u_fwd (
        .clk(clk), .rst_n(rst_n), .take(take), .byte_in(up_data),
        .dn_ready(dn_ready), .dn_data(dn_data), .dn_valid(dn_valid),
        .free(fwd_free)
    );
endmodule

// File: rtl/ring_xport_node_chk.sv
// Port-level protocol checks for ring_xport_node, attached with bind.
module ring_xport_node_chk #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] up_data,
    input logic              up_valid,
    input logic              up_ready,
    input logic [BYTE_W-1:0] dn_data,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [WORD_W-1:0] wd_data,
    input logic              wd_valid,
    input logic              wd_ready
);
    // R2: accepted byte reappears downstream next cycle.
    p_fwd_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> (dn_valid && dn_data == $past(up_data)));

    // R9: a stalled downstream byte holds.
    p_dn_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

    // R9: a stalled downstream blocks upstream.
    p_dn_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |-> !up_ready);

    // R8: a pending word holds.
    p_wd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_data)));
endmodule

bind ring_xport_node ring_xport_node_chk #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_valid(up_valid),
    .up_ready(up_ready), .dn_data(dn_data), .dn_valid(dn_valid),
    .dn_ready(dn_ready), .wd_data(wd_data), .wd_valid(wd_valid),
    .wd_ready(wd_ready)
);

// File: tb/ring_xport_node_tb.sv
module ring_xport_node_tb;
    localparam int NSTIM = 26;
    localparam int NWORD = 6;
    // Stream: own(2 words), foreign 7 (1 word of fake headers), own zero-length,
    // own(1 word), foreign 9 zero-length.
    localparam logic [7:0] STIM [NSTIM] = '{
        8'h05, 8'h02, 8'h44, 8'h33, 8'h22, 8'h11, 8'h05, 8'hA5, 8'hA5, 8'hA5,
        8'h07, 8'h01, 8'h05, 8'h02, 8'h05, 8'h05,
        8'h05, 8'h00,
        8'h05, 8'h01, 8'hEF, 8'hBE, 8'hAD, 8'hDE,
        8'h09, 8'h00 };
    localparam logic [31:0] EXP_W [NWORD] = '{
        32'h11223344, 32'hA5A5A505, 32'hDEADBEEF,
        32'h04030201, 32'h0D0C0B0A, 32'h44332211 };

    logic        clk = 0, rst_n = 0;
    logic [7:0]  up_data = 0;
    logic        up_valid = 0, dn_ready = 1, wd_ready = 1;
    logic        up_ready, dn_valid, wd_valid;
    logic [7:0]  dn_data;
    logic [31:0] wd_data;

    int n_tests = 0, n_fail = 0, w_idx = 0, q_wr = 0, q_rd = 0;
    logic [7:0] q [256];

    always #4 clk = ~clk;

    ring_xport_node #(.NODE_ID(8'h05)) u_dut (
        .clk(clk), .rst_n(rst_n), .up_data(up_data), .up_valid(up_valid),
        .up_ready(up_ready), .dn_data(dn_data), .dn_valid(dn_valid),
        .dn_ready(dn_ready), .wd_data(wd_data), .wd_valid(wd_valid),
        .wd_ready(wd_ready));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor between edges: forwarded bytes (R2) and delivered words (R3-R6).
    always @(negedge clk) begin
        if (rst_n) begin
            if (dn_valid && dn_ready) begin
                chk(q_rd < q_wr && dn_data == q[q_rd[7:0]], "R2", "forwarded byte",
                    32'(dn_data), 32'(q[q_rd[7:0]]));
                q_rd++;
            end
            if (up_valid && up_ready) begin
                q[q_wr[7:0]] = up_data;
                q_wr++;
            end
            if (wd_valid && wd_ready) begin
                if (w_idx < NWORD)
                    chk(wd_data == EXP_W[w_idx], "R4", "word value", wd_data, EXP_W[w_idx]);
                else
                    chk(1'b0, "R6", "unexpected word", wd_data, 32'h0);
                w_idx++;
            end
        end
    end

    task automatic put(input logic [7:0] b);
        @(posedge clk); #1; up_data = b; up_valid = 1;
        do @(negedge clk); while (!up_ready);
        @(posedge clk); #1; up_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(!dn_valid, "R1", "dn_valid after reset", 32'(dn_valid), 0);
        chk(!wd_valid, "R1", "wd_valid after reset", 32'(wd_valid), 0);
        chk(up_ready, "R1", "up_ready after reset", 32'(up_ready), 1);

        // Table walk: R3, R5, R6, R7 across mixed segments.
        for (int i = 0; i < NSTIM; i++) put(STIM[i]);
        repeat (4) @(negedge clk);
        chk(w_idx == 3, "R5", "words after table", 32'(w_idx), 3);

        // R10 timing and R8 word backpressure.
        wd_ready = 0;
        put(8'h05); put(8'h02); put(8'h01); put(8'h02); put(8'h03);
        @(negedge clk);
        chk(!wd_valid, "R10", "no word before fourth byte", 32'(wd_valid), 0);
        put(8'h04);
        @(negedge clk);
        chk(wd_valid, "R10", "word after fourth byte", 32'(wd_valid), 1);
        chk(wd_data == 32'h04030201, "R4", "held word", wd_data, 32'h04030201);
        put(8'h0A); put(8'h0B); put(8'h0C);
        @(posedge clk); #1; up_data = 8'h0D; up_valid = 1;
        @(negedge clk);
        chk(!up_ready, "R8", "stall on completing byte", 32'(up_ready), 0);
        @(posedge clk); @(negedge clk);
        chk(!up_ready, "R8", "stall persists", 32'(up_ready), 0);
        chk(wd_data == 32'h04030201, "R8", "word stable", wd_data, 32'h04030201);
        @(posedge clk); #1; wd_ready = 1;
        @(negedge clk);
        chk(up_ready, "R8", "released when kernel ready", 32'(up_ready), 1);
        @(posedge clk); #1; up_valid = 0;
        repeat (3) @(negedge clk);
        chk(w_idx == 5, "R8", "no word lost", 32'(w_idx), 5);

        // R9 downstream stall with a foreign zero-length segment.
        put(8'h07);
        dn_ready = 0; up_data = 8'h00; up_valid = 1;
        @(negedge clk);
        chk(!up_ready, "R9", "blocked by downstream", 32'(up_ready), 0);
        chk(dn_data == 8'h07, "R9", "dn byte", 32'(dn_data), 32'h07);
        @(posedge clk); @(negedge clk);
        chk(dn_valid && dn_data == 8'h07, "R9", "dn byte held", 32'(dn_data), 32'h07);
        @(posedge clk); #1; dn_ready = 1;
        @(negedge clk);
        @(posedge clk); #1; up_valid = 0;

        // R1 reset mid-word discards the partial word.
        put(8'h05); put(8'h01); put(8'hAA);
        @(negedge clk);
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk(!dn_valid && !wd_valid && up_ready, "R1", "state after mid reset",
            {29'h0, dn_valid, wd_valid, up_ready}, 32'h1);
        put(8'h05); put(8'h01); put(8'h11); put(8'h22); put(8'h33); put(8'h44);
        repeat (4) @(negedge clk);
        chk(w_idx == NWORD, "R5", "total words", 32'(w_idx), NWORD);
        chk(q_rd == q_wr, "R2", "all bytes forwarded", 32'(q_rd), 32'(q_wr));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule